// File: doc/BRIEF.md
# Card Slot Presence and Interrupt Controller

This block watches the pins of a removable flash card slot and turns them into a small register view plus one interrupt line. The card-detect, write-protect and ready/busy pins pass through a multi-flop synchroniser. The synchronised levels are shown in a read-only status register. A rising edge of synchronised presence records an insert event, and a falling edge records a remove event. Both events sit in a write-1-to-clear event register.

An enable register gates the interrupt line. It holds one enable per event and a global enable above both. Debouncing is left to software. After each event, software waits for the slot to settle, clears the event and arms only the edge opposite to the current presence state. The byte register interface has three locations. A write takes effect at the clock edge where the write strobe is high. Read data is combinational from the address.

Top module: `card_slot_irq`

## Requirements
- R1: Address 0 (slot status) reads bit 1 = write-protect pin, bit 2 = card-detect pin and bit 7 = busy (ready pin low), with all other bits 0. Each bit follows its pin exactly SYNC_STAGES rising clock edges after the pin changes.
- R2: A 0-to-1 change of synchronised presence sets event bit 3 (insert) at address 1 one edge after it shows in the status. This happens whether or not the insert event is enabled.
- R3: A 1-to-0 change of synchronised presence sets event bit 2 (remove) at address 1, whether or not the remove event is enabled.
- R4: Writing address 1 clears each event bit written as 1. Event bits written as 0 keep their value.
- R5: Address 2 (enable) holds bit 2 = remove enable, bit 3 = insert enable and bit 7 = global enable. It is writable and reads back these bits, with every other bit reading 0.
- R6: The irq output is high exactly when the global enable is set and some event bit is set together with its own enable.
- R7: Reserved event bits read 0 and writes to them have no effect. Writes to address 0 change nothing.
- R8: When an edge event and a write-1 clear of the same bit meet at one clock edge, the event bit ends up set.
- R9: During and just after the active-low synchronous reset, every register reads 0 and irq is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| slot_cd | input | 1 | Raw card-detect pin, high when a card is present |
| slot_wp | input | 1 | Raw write-protect pin, high when the card is read-only |
| slot_rdy | input | 1 | Raw ready/busy pin, low while the card is busy |
| reg_addr | input | 2 | Register address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| irq | output | 1 | Card interrupt request |

## Verification
The bench builds the block with SYNC_STAGES set to 3 rather than the default 2. It derives every wait and every sampling point from that value. This shows that latency follows the parameter, not a fixed two-cycle pipeline. The exact-edge presence check and the set-over-clear race both depend on that count. With three stages the race lands one cycle later than at the default, which brings the parameterised timing path within reach of the checks.

// File: rtl/card_slot_pkg.sv
// Package: shared register addresses and bit positions for the card slot
// presence and interrupt controller. Assumes a 2-bit byte register address.
package card_slot_pkg;
    localparam int ADDR_W = 2;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_EVT  = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_EN   = 2'd2;

    localparam int BIT_RO   = 1;
    localparam int BIT_PRS  = 2;
    localparam int BIT_BUSY = 7;
    localparam int BIT_REM  = 2;
    localparam int BIT_INS  = 3;
    localparam int BIT_GLB  = 7;

    localparam logic [DATA_W-1:0] INS_MASK = 8'h08;
    localparam logic [DATA_W-1:0] REM_MASK = 8'h04;
    localparam logic [DATA_W-1:0] EN_MASK  = 8'h8C;
endpackage

// File: rtl/card_slot_sync.sv
// Module: multi-stage synchroniser for a vector of slow asynchronous pins.
// Assumes each pin is quasi-static compared with the clock; every stage
// resets to zero synchronously.
module card_slot_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stg [STAGES];

    // Stage 0 samples the raw pins.
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= pin_i;
    end

    genvar s;
    generate
        for (s = 1; s < STAGES; s++) begin : g_stage
            // Each further stage resamples the previous one.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= '0;
                else        stg[s] <= stg[s-1];
            end
        end
    endgenerate

    assign sync_o = stg[STAGES-1];
endmodule

// File: rtl/card_slot_evt.sv
// Module: insert/remove edge detector with sticky write-1-to-clear event bits.
// Assumes prs_i is already synchronised. A new edge wins over a clear that
// arrives at the same clock edge.
module card_slot_evt (
    input  logic clk,
    input  logic rst_n,
    input  logic prs_i,
    input  logic clr_ins_i,
    input  logic clr_rem_i,
    output logic ins_o,
    output logic rem_o
);
    logic prs_q;
    logic rise;
    logic fall;

    // Holds last cycle's presence level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prs_q <= 1'b0;
        else        prs_q <= prs_i;
    end

    assign rise = prs_i & ~prs_q;
    assign fall = ~prs_i & prs_q;

    // Sticky insert and remove bits: a set beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ins_o <= 1'b0;
            rem_o <= 1'b0;
        end else begin
            ins_o <= rise | (ins_o & ~clr_ins_i);
            rem_o <= fall | (rem_o & ~clr_rem_i);
        end
    end

    assert_ins_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prs_i) |=> ins_o);
    assert_rem_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prs_i) |=> rem_o);
    assert_w1c_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ins_i && !(prs_i && !prs_q)) |=> !ins_o);
    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_rem_i && $fell(prs_i)) |=> rem_o);
endmodule

// File: rtl/card_slot_irq.sv
// Module: card slot presence/status registers and interrupt generation.
// Assumes a single-cycle write strobe and combinational read data.
// Address 0 is read-only status, 1 is write-1-to-clear events, 2 is enables.
module card_slot_irq
    import card_slot_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot_cd,
    input  logic              slot_wp,
    input  logic              slot_rdy,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    localparam int NPIN = 3;

    logic [NPIN-1:0]   pin_s;
    logic              ins_evt;
    logic              rem_evt;
    logic [DATA_W-1:0] en_q;
    logic [DATA_W-1:0] stat_v;
    logic [DATA_W-1:0] evt_v;
    logic              evt_wr;
    logic              clr_ins;
    logic              clr_rem;

    card_slot_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  ({~slot_rdy, slot_wp, slot_cd}),
        .sync_o (pin_s)
    );

    assign evt_wr  = reg_we && (reg_addr == ADDR_EVT);
    assign clr_ins = evt_wr && |(reg_wdata & INS_MASK);
    assign clr_rem = evt_wr && |(reg_wdata & REM_MASK);

    card_slot_evt u_evt (
        .clk       (clk),
        .rst_n     (rst_n),
        .prs_i     (pin_s[0]),
        .clr_ins_i (clr_ins),
        .clr_rem_i (clr_rem),
        .ins_o     (ins_evt),
        .rem_o     (rem_evt)
    );

    // Enable register: only the defined enable bits are stored.
    always_ff @(posedge clk) begin
        if (!rst_n)                                en_q <= '0;
        else if (reg_we && reg_addr == ADDR_EN)    en_q <= reg_wdata & EN_MASK;
    end

    // Assemble status and event views with reserved bits held at zero.
    always_comb begin
        stat_v           = '0;
        stat_v[BIT_PRS]  = pin_s[0];
        stat_v[BIT_RO]   = pin_s[1];
        stat_v[BIT_BUSY] = pin_s[2];
        evt_v            = '0;
        evt_v[BIT_INS]   = ins_evt;
        evt_v[BIT_REM]   = rem_evt;
    end

    // Read multiplexer.
    always_comb begin
        case (reg_addr)
            ADDR_STAT: reg_rdata = stat_v;
            ADDR_EVT:  reg_rdata = evt_v;
            ADDR_EN:   reg_rdata = en_q;
            default:   reg_rdata = '0;
        endcase
    end

    assign irq = en_q[BIT_GLB] & |(evt_v & en_q);

    assert_resv_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_EVT) |-> ((reg_rdata & ~(INS_MASK | REM_MASK)) == '0));
endmodule

// File: tb/sim_card_slot_irq.sv
`timescale 1ns/1ps
module sim_card_slot_irq;
    localparam int LAT = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slot_cd = 1'b0, slot_wp = 1'b0, slot_rdy = 1'b1;
    logic [1:0] reg_addr = 2'd0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    card_slot_irq #(.SYNC_STAGES(LAT)) u0 (
        .clk(clk), .rst_n(rst_n), .slot_cd(slot_cd), .slot_wp(slot_wp),
        .slot_rdy(slot_rdy), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

    // Vector table: {cd, wp, rdy, expected status byte}
    localparam logic [10:0] VEC [6] = '{
        {3'b001, 8'h00}, {3'b101, 8'h04}, {3'b111, 8'h06},
        {3'b110, 8'h86}, {3'b000, 8'h80}, {3'b011, 8'h02}};

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(posedge clk); @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        logic [7:0] d;
        @(negedge clk); cyc(2);
        // R9: reset state
        rd(2'd0, d); check("R9 status", d, 8'h00);
        rd(2'd1, d); check("R9 events", d, 8'h00);
        rd(2'd2, d); check("R9 enable", d, 8'h00);
        check("R9 irq", {7'd0, irq}, 8'h00);
        rst_n = 1'b1;
        cyc(1);
        check("R9 irq after release", {7'd0, irq}, 8'h00);

        // R1: status vectors
        for (int i = 0; i < 6; i++) begin
            {slot_cd, slot_wp, slot_rdy} = VEC[i][10:8];
            cyc(LAT + 1);
            rd(2'd0, d); check("R1 status vector", d, VEC[i][7:0]);
        end
        wr(2'd1, 8'hFF);
        rd(2'd1, d); check("R4 clear all", d, 8'h00);

        // R1 exact latency, then R2 insert without enable
        slot_cd = 1'b1;
        cyc(LAT - 1);
        rd(2'd0, d); check("R1 before latency", d & 8'h04, 8'h00);
        cyc(1);
        rd(2'd0, d); check("R1 at latency", d & 8'h04, 8'h04);
        rd(2'd1, d); check("R2 not yet", d, 8'h00);
        cyc(1);
        rd(2'd1, d); check("R2 insert latched", d, 8'h08);
        check("R6 irq no enable", {7'd0, irq}, 8'h00);

        // R6 gating
        wr(2'd2, 8'h08);
        check("R6 irq no global", {7'd0, irq}, 8'h00);
        wr(2'd2, 8'h88);
        check("R6 irq armed", {7'd0, irq}, 8'h01);
        // R5 readback and masking
        wr(2'd2, 8'hFF);
        rd(2'd2, d); check("R5 enable readback", d, 8'h8C);

        // R4 partial clear
        wr(2'd1, 8'h04);
        rd(2'd1, d); check("R4 zero bit keeps", d, 8'h08);
        wr(2'd1, 8'h08);
        rd(2'd1, d); check("R4 bit cleared", d, 8'h00);
        check("R4 irq dropped", {7'd0, irq}, 8'h00);

        // R3 remove
        slot_cd = 1'b0;
        cyc(LAT + 2);
        rd(2'd1, d); check("R3 remove latched", d, 8'h04);
        check("R6 irq on remove", {7'd0, irq}, 8'h01);
        wr(2'd2, 8'h88);
        check("R6 remove disabled", {7'd0, irq}, 8'h00);

        // R7 reserved bits and status writes
        wr(2'd1, 8'h13);
        rd(2'd1, d); check("R7 reserved write", d, 8'h04);
        wr(2'd0, 8'hFF);
        rd(2'd0, d); check("R7 status write ignored", d, 8'h02);
        wr(2'd1, 8'h0C);

        // R8 set wins over same-edge clear
        slot_cd = 1'b1;
        cyc(LAT);
        reg_addr = 2'd1; reg_wdata = 8'h08; reg_we = 1'b1;
        @(posedge clk); @(negedge clk);
        reg_we = 1'b0;
        rd(2'd1, d); check("R8 set wins", d, 8'h08);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule